// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps the coherence state of every line in a small direct-mapped cache that sits on a shared snooping bus. Each line is in one of four states: Modified (dirty, sole copy), Exclusive (clean, sole copy), Shared (clean, other copies may exist) or Invalid. The processor side asks for reads and writes with a held request that a one-cycle done pulse ends. The done pulse carries the state the line ended in. When the line is not usable as it stands, the block issues a bus request and waits for the bus to acknowledge it.

On the snoop side, the block sees reads and intent-to-write transactions from other agents. For each one it produces a one-cycle response: a shared flag, and a flush strobe that marks where dirty data must be written back. The clean-exclusive state is picked from the bus shared line on a read fill. A later write to that line then becomes Modified with no bus traffic at all. A snoop takes precedence over a processor request to the same index in the same cycle.

Top module: `coh_line_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, cpu_done, bus_req_valid and snp_resp_valid are low. After reset every line is Invalid, so the first access to any address misses.
- R2: A read miss issues bus op 0 (plain read) for the requested address. The line then ends in Exclusive (state code 2) if bus_shared_in was low at the acknowledge, or in Shared (code 1) if it was high. State codes are I=0, S=1, E=2, M=3.
- R3: A read that hits a valid line completes with no bus request and reports the line's current state.
- R4: A write that hits an Exclusive or Modified line completes with no bus request and leaves the line Modified.
- R5: A write that hits a Shared line issues bus op 2 (invalidate). A write that misses issues bus op 1 (read-for-ownership). Both end in Modified.
- R6: A snooped intent-to-write (snp_op=1) that hits a valid line makes it Invalid. It strobes snp_flush only if the line was Modified, and never raises snp_shared.
- R7: A snooped read (snp_op=0) that hits a Modified line raises snp_flush and snp_shared and moves the line to Shared, so no Modified copy survives next to a reader.
- R8: A snooped read that hits an Exclusive or Shared line raises snp_shared with no flush and leaves the line Shared. A snoop that misses responds with both flags low.
- R9: A miss whose victim line is Modified first issues bus op 3 (write-back) carrying the victim's address, then the fill request. A clean victim is replaced with no write-back.
- R10: When a snoop and a processor request hit the same index in the same cycle, the snoop is applied first and the processor request is accepted one cycle later against the updated state. Requests to different indices proceed together.
- R11: cpu_done rises one cycle after a hit is accepted, or one cycle after the final bus_ack of a miss or upgrade. snp_resp_valid follows each snp_valid by one cycle. A bus request holds its op and address until bus_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request, held until cpu_done |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_state | output | 2 | Line state after completion (I=0, S=1, E=2, M=3) |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_op | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_req_addr | output | ADDR_W | Line address of the bus request |
| bus_ack | input | 1 | One-cycle acknowledge of the pending request |
| bus_shared_in | input | 1 | Shared line from other caches, valid with bus_ack |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 1 | 0 read, 1 intent-to-write |
| snp_addr | input | ADDR_W | Line address of the snooped transaction |
| snp_resp_valid | output | 1 | Snoop response present |
| snp_shared | output | 1 | This cache holds a copy (reads only) |
| snp_flush | output | 1 | Dirty copy must be written back |

## Verification
A hit completes on the first cycle after acceptance. A clean miss or an upgrade completes two cycles after the request is raised. A dirty eviction adds two more cycles for the write-back handshake. A snoop that collides with a processor request delays that request by exactly one cycle. The bench sets the request on a falling edge and counts falling edges until cpu_done, then compares the count against these figures. Snoop responses, bus requests and completion states are compared in arrival order against a queue of expected events, so any extra, missing or reordered bus transaction shows up as a mismatch.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BOP_RD  = 2'd0,
    BOP_RDX = 2'd1,
    BOP_INV = 2'd2,
    BOP_WB  = 2'd3
  } bus_op_t;

  localparam logic SOP_READ = 1'b0;
  localparam logic SOP_ITW  = 1'b1;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] cpu_idx,
  output logic [TAG_W-1:0] cpu_rd_tag,
  output line_st_t         cpu_rd_st,
  input  logic             cpu_we,
  input  logic [IDX_W-1:0] cpu_wr_idx,
  input  logic [TAG_W-1:0] cpu_wr_tag,
  input  line_st_t         cpu_wr_st,
  input  logic [IDX_W-1:0] snp_idx,
  output logic [TAG_W-1:0] snp_rd_tag,
  output line_st_t         snp_rd_st,
  input  logic             snp_we,
  input  line_st_t         snp_wr_st
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  line_st_t         st_q  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit_snp, hit_cpu;
    assign hit_snp = snp_we && (snp_idx == IDX_W'(g));
    assign hit_cpu = cpu_we && (cpu_wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g] <= LS_I;
      end else if (hit_snp) begin
        st_q[g] <= snp_wr_st;
      end else if (hit_cpu) begin
        st_q[g] <= cpu_wr_st;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        tag_q[g] <= '0;
      end else if (hit_cpu) begin
        tag_q[g] <= cpu_wr_tag;
      end
    end
  end

  assign cpu_rd_tag = tag_q[cpu_idx];
  assign cpu_rd_st  = st_q[cpu_idx];
  assign snp_rd_tag = tag_q[snp_idx];
  assign snp_rd_st  = st_q[snp_idx];
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             snp_valid,
  input  logic             snp_op,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] rd_tag,
  input  line_st_t         rd_st,
  output logic             st_we,
  output line_st_t         st_wr,
  output logic             resp_valid,
  output logic             resp_shared,
  output logic             resp_flush
);
  logic hit;
  logic shared_n, flush_n;

  always_comb begin
    hit      = snp_valid && (rd_st != LS_I) && (rd_tag == snp_tag);
    st_wr    = (snp_op == SOP_ITW) ? LS_I : LS_S;
    st_we    = hit && (st_wr != rd_st);
    shared_n = hit && (snp_op == SOP_READ);
    flush_n  = hit && (rd_st == LS_M);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_shared <= 1'b0;
      resp_flush  <= 1'b0;
    end else begin
      resp_valid  <= snp_valid;
      resp_shared <= shared_n;
      resp_flush  <= flush_n;
    end
  end
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              blocked,
  input  logic [ADDR_W-IDX_W-1:0] look_tag,
  input  line_st_t          look_st,
  input  logic              bus_ack,
  input  logic              bus_shared_in,
  output logic              cpu_done,
  output line_st_t          cpu_state,
  output logic              bus_req_valid,
  output bus_op_t           bus_req_op,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic              st_we,
  output logic [IDX_W-1:0]  st_idx,
  output logic [ADDR_W-IDX_W-1:0] st_tag,
  output line_st_t          st_wr
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [2:0] {F_IDLE, F_WB, F_FILL, F_UPG, F_RESP} fsm_t;

  fsm_t              fsm_q;
  logic              req_write_q;
  logic [ADDR_W-1:0] req_addr_q;

  logic [IDX_W-1:0] cpu_idx, req_idx;
  logic [TAG_W-1:0] cpu_tag, req_tag;
  logic             hit, accept;
  line_st_t         fill_st;

  always_comb begin
    cpu_idx = cpu_addr[IDX_W-1:0];
    cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    req_idx = req_addr_q[IDX_W-1:0];
    req_tag = req_addr_q[ADDR_W-1:IDX_W];
    hit     = (look_st != LS_I) && (look_tag == cpu_tag);
    accept  = (fsm_q == F_IDLE) && cpu_valid && !blocked;
    if (req_write_q)        fill_st = LS_M;
    else if (bus_shared_in) fill_st = LS_S;
    else                    fill_st = LS_E;
  end

  always_comb begin
    st_we  = 1'b0;
    st_idx = req_idx;
    st_tag = req_tag;
    st_wr  = LS_M;
    unique case (fsm_q)
      F_IDLE: begin
        st_idx = cpu_idx;
        st_tag = cpu_tag;
        st_we  = accept && hit && cpu_write && (look_st == LS_E);
      end
      F_WB: begin
        st_we = bus_ack;
        st_wr = LS_I;
      end
      F_FILL: begin
        st_we = bus_ack;
        st_wr = fill_st;
      end
      F_UPG: begin
        st_we = bus_ack;
      end
      default: st_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q         <= F_IDLE;
      req_write_q   <= 1'b0;
      req_addr_q    <= '0;
      cpu_done      <= 1'b0;
      cpu_state     <= LS_I;
      bus_req_valid <= 1'b0;
      bus_req_op    <= BOP_RD;
      bus_req_addr  <= '0;
    end else begin
      unique case (fsm_q)
        F_IDLE: begin
          cpu_done <= 1'b0;
          if (accept) begin
            req_write_q <= cpu_write;
            req_addr_q  <= cpu_addr;
            if (hit && (!cpu_write || look_st != LS_S)) begin
              cpu_done  <= 1'b1;
              cpu_state <= cpu_write ? LS_M : look_st;
              fsm_q     <= F_RESP;
            end else if (hit) begin
              bus_req_valid <= 1'b1;
              bus_req_op    <= BOP_INV;
              bus_req_addr  <= cpu_addr;
              fsm_q         <= F_UPG;
            end else if (look_st == LS_M) begin
              bus_req_valid <= 1'b1;
              bus_req_op    <= BOP_WB;
              bus_req_addr  <= {look_tag, cpu_idx};
              fsm_q         <= F_WB;
            end else begin
              bus_req_valid <= 1'b1;
              bus_req_op    <= cpu_write ? BOP_RDX : BOP_RD;
              bus_req_addr  <= cpu_addr;
              fsm_q         <= F_FILL;
            end
          end
        end
        F_WB: begin
          if (bus_ack) begin
            bus_req_op   <= req_write_q ? BOP_RDX : BOP_RD;
            bus_req_addr <= req_addr_q;
            fsm_q        <= F_FILL;
          end
        end
        F_FILL, F_UPG: begin
          if (bus_ack) begin
            bus_req_valid <= 1'b0;
            cpu_done      <= 1'b1;
            cpu_state     <= (fsm_q == F_UPG) ? LS_M : fill_st;
            fsm_q         <= F_RESP;
          end
        end
        default: begin
          cpu_done <= 1'b0;
          fsm_q    <= F_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic [1:0]        cpu_state,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_op,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_ack,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic              snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_resp_valid,
  output logic              snp_shared,
  output logic              snp_flush
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] cpu_idx, snp_idx, st_idx;
  logic [TAG_W-1:0] cpu_rd_tag, snp_rd_tag, st_tag;
  line_st_t         cpu_rd_st, snp_rd_st, st_wr, snp_wr, cpu_state_e;
  bus_op_t          bus_op_e;
  logic             st_we, snp_we, blocked;

  assign cpu_idx   = cpu_addr[IDX_W-1:0];
  assign snp_idx   = snp_addr[IDX_W-1:0];
  assign blocked   = snp_valid && (snp_idx == cpu_idx);
  assign cpu_state = cpu_state_e;
  assign bus_req_op = bus_op_e;

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) store_i (
    .clk(clk), .rst(rst),
    .cpu_idx(cpu_idx), .cpu_rd_tag(cpu_rd_tag), .cpu_rd_st(cpu_rd_st),
    .cpu_we(st_we), .cpu_wr_idx(st_idx), .cpu_wr_tag(st_tag), .cpu_wr_st(st_wr),
    .snp_idx(snp_idx), .snp_rd_tag(snp_rd_tag), .snp_rd_st(snp_rd_st),
    .snp_we(snp_we), .snp_wr_st(snp_wr)
  );

  coh_snoop_unit #(.TAG_W(TAG_W)) snoop_i (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .rd_tag(snp_rd_tag), .rd_st(snp_rd_st),
    .st_we(snp_we), .st_wr(snp_wr),
    .resp_valid(snp_resp_valid), .resp_shared(snp_shared), .resp_flush(snp_flush)
  );

  coh_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) fsm_i (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .blocked(blocked), .look_tag(cpu_rd_tag), .look_st(cpu_rd_st),
    .bus_ack(bus_ack), .bus_shared_in(bus_shared_in),
    .cpu_done(cpu_done), .cpu_state(cpu_state_e),
    .bus_req_valid(bus_req_valid), .bus_req_op(bus_op_e), .bus_req_addr(bus_req_addr),
    .st_we(st_we), .st_idx(st_idx), .st_tag(st_tag), .st_wr(st_wr)
  );
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_write,
  input logic              cpu_done,
  input logic [1:0]        cpu_state,
  input logic              bus_req_valid,
  input logic [1:0]        bus_req_op,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              bus_ack,
  input logic              snp_valid,
  input logic              snp_op,
  input logic              snp_resp_valid,
  input logic              snp_shared,
  input logic              snp_flush
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !cpu_done && !bus_req_valid && !snp_resp_valid); // R1

  AST_DONE_NOT_INVALID: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> cpu_state != 2'd0); // R2

  AST_WRITE_ENDS_MODIFIED: assert property (@(posedge clk) disable iff (rst)
    cpu_done && cpu_write |-> cpu_state == 2'd3); // R4

  AST_FLUSH_IN_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    snp_flush |-> snp_resp_valid); // R7

  AST_SHARED_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
    snp_shared |-> $past(snp_valid) && !$past(snp_op)); // R8

  AST_SNOOP_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    snp_valid |=> snp_resp_valid); // R11

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid && !bus_ack |=> bus_req_valid && $stable(bus_req_op) && $stable(bus_req_addr)); // R11

  AST_ACK_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid && bus_ack && bus_req_op != 2'd3 |=> cpu_done); // R11

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done); // R11
endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .cpu_write(cpu_write), .cpu_done(cpu_done), .cpu_state(cpu_state),
  .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op), .bus_req_addr(bus_req_addr),
  .bus_ack(bus_ack), .snp_valid(snp_valid), .snp_op(snp_op),
  .snp_resp_valid(snp_resp_valid), .snp_shared(snp_shared), .snp_flush(snp_flush)
);

// File: tb/coh_line_ctrl_tb_top.sv
module coh_line_ctrl_tb_top;
  localparam int AW = 12;
  localparam int K_BUS = 0, K_DONE = 1, K_SNP = 2;
  localparam int ST_I = 0, ST_S = 1, ST_E = 2, ST_M = 3;
  localparam int OP_RD = 0, OP_RDX = 1, OP_INV = 2, OP_WB = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_done;
  logic [1:0]    cpu_state;
  logic          bus_req_valid;
  logic [1:0]    bus_req_op;
  logic [AW-1:0] bus_req_addr;
  logic          bus_ack = 1'b0, bus_shared_in = 1'b0;
  logic          snp_valid = 1'b0, snp_op = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_resp_valid, snp_shared, snp_flush;

  coh_line_ctrl #(.ADDR_W(AW), .IDX_W(3)) dut_i (.*);

  typedef struct {int kind; int a; int b; string tag;} exp_t;
  exp_t exp_q[$];
  int   n_cmp = 0, n_bad = 0;
  logic shared_plan = 1'b0;

  function automatic void push(int kind, int a, int b, string tag);
    exp_t e;
    e.kind = kind; e.a = a; e.b = b; e.tag = tag;
    exp_q.push_back(e);
  endfunction

  function automatic void compare(int kind, int a, int b);
    exp_t e;
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL R11 unexpected event: actual kind=%0d a=%0d b=%0h expected none", kind, a, b);
      return;
    end
    e = exp_q.pop_front();
    if (e.kind != kind || e.a != a || e.b != b) begin
      n_bad++;
      $display("FAIL %s: actual kind=%0d a=%0d b=%0h expected kind=%0d a=%0d b=%0h",
               e.tag, kind, a, b, e.kind, e.a, e.b);
    end
  endfunction

  // bus model and monitor in one process: fixed order snoop, bus, done
  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 1'b0;
    end else begin
      if (snp_resp_valid) compare(K_SNP, int'(snp_shared), int'(snp_flush));
      if (bus_req_valid && !bus_ack) begin
        compare(K_BUS, int'(bus_req_op), int'(bus_req_addr));
        bus_ack       = 1'b1;
        bus_shared_in = shared_plan;
      end else begin
        bus_ack = 1'b0;
      end
      if (cpu_done) compare(K_DONE, int'(cpu_state), 0);
    end
  end

  task automatic do_cpu(input bit wr, input int addr, input bit sh, input int exp_cyc,
                        input string tag, input bit with_snp = 0, input bit sop = 0,
                        input int saddr = 0);
    int cyc;
    @(negedge clk);
    shared_plan = sh;
    cpu_write = wr;
    cpu_addr = AW'(addr);
    cpu_valid = 1'b1;
    if (with_snp) begin
      snp_op = sop;
      snp_addr = AW'(saddr);
      snp_valid = 1'b1;
    end
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      snp_valid = 1'b0;
    end while (!cpu_done && cyc < 50);
    cpu_valid = 1'b0;
    n_cmp++;
    if (cyc != exp_cyc) begin
      n_bad++;
      $display("FAIL R11 (%s) done latency: actual=%0d expected=%0d", tag, cyc, exp_cyc);
    end
  endtask

  task automatic do_snoop(input bit op, input int addr);
    @(negedge clk);
    snp_op = op;
    snp_addr = AW'(addr);
    snp_valid = 1'b1;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R11 watchdog expired: actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (cpu_done || bus_req_valid || snp_resp_valid) begin
      n_bad++;
      $display("FAIL R1 outputs in reset: actual=%0b%0b%0b expected=000",
               cpu_done, bus_req_valid, snp_resp_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    n_cmp++;
    if (cpu_done || bus_req_valid || snp_resp_valid) begin
      n_bad++;
      $display("FAIL R1 outputs after reset: actual=%0b%0b%0b expected=000",
               cpu_done, bus_req_valid, snp_resp_valid);
    end

    // R1 R2: cold read miss, no sharer -> Exclusive
    push(K_BUS, OP_RD, 'h010, "R2"); push(K_DONE, ST_E, 0, "R2");
    do_cpu(0, 'h010, 0, 2, "R2");
    // R3: read hit
    push(K_DONE, ST_E, 0, "R3");
    do_cpu(0, 'h010, 0, 1, "R3");
    // R4: silent E->M, then M write hit
    push(K_DONE, ST_M, 0, "R4");
    do_cpu(1, 'h010, 0, 1, "R4");
    push(K_DONE, ST_M, 0, "R4");
    do_cpu(1, 'h010, 0, 1, "R4");
    // R7: snooped read of Modified
    push(K_SNP, 1, 1, "R7");
    do_snoop(0, 'h010);
    push(K_DONE, ST_S, 0, "R7");
    do_cpu(0, 'h010, 0, 1, "R7");
    // R5: write to Shared upgrades with invalidate
    push(K_BUS, OP_INV, 'h010, "R5"); push(K_DONE, ST_M, 0, "R5");
    do_cpu(1, 'h010, 0, 2, "R5");
    // R6: intent-to-write on Modified flushes, line invalid
    push(K_SNP, 0, 1, "R6");
    do_snoop(1, 'h010);
    push(K_BUS, OP_RD, 'h010, "R2"); push(K_DONE, ST_S, 0, "R2");
    do_cpu(0, 'h010, 1, 2, "R2");
    // R6: intent-to-write on Shared, then R5 write miss
    push(K_SNP, 0, 0, "R6");
    do_snoop(1, 'h010);
    push(K_BUS, OP_RDX, 'h010, "R5"); push(K_DONE, ST_M, 0, "R5");
    do_cpu(1, 'h010, 0, 2, "R5");
    // R8: snoop miss, snoop read of Exclusive
    push(K_SNP, 0, 0, "R8");
    do_snoop(0, 'h123);
    push(K_BUS, OP_RD, 'h021, "R2"); push(K_DONE, ST_E, 0, "R2");
    do_cpu(0, 'h021, 0, 2, "R2");
    push(K_SNP, 1, 0, "R8");
    do_snoop(0, 'h021);
    push(K_DONE, ST_S, 0, "R8");
    do_cpu(0, 'h021, 0, 1, "R8");
    // R9: dirty victim written back first, then clean victim dropped
    push(K_BUS, OP_WB, 'h010, "R9"); push(K_BUS, OP_RD, 'h018, "R9");
    push(K_DONE, ST_E, 0, "R9");
    do_cpu(0, 'h018, 0, 4, "R9");
    push(K_BUS, OP_RD, 'h010, "R9"); push(K_DONE, ST_S, 0, "R9");
    do_cpu(0, 'h010, 1, 2, "R9");
    // R10: same-index collision, snoop first
    push(K_BUS, OP_RD, 'h032, "R2"); push(K_DONE, ST_E, 0, "R2");
    do_cpu(0, 'h032, 0, 2, "R2");
    push(K_SNP, 1, 0, "R10"); push(K_BUS, OP_INV, 'h032, "R10");
    push(K_DONE, ST_M, 0, "R10");
    do_cpu(1, 'h032, 0, 3, "R10", 1, 0, 'h032);
    // R10: different indices proceed together
    push(K_SNP, 0, 0, "R10"); push(K_DONE, ST_S, 0, "R10");
    do_cpu(0, 'h021, 0, 1, "R10", 1, 1, 'h010);
    push(K_BUS, OP_RD, 'h010, "R6"); push(K_DONE, ST_E, 0, "R6");
    do_cpu(0, 'h010, 0, 2, "R6");

    repeat (4) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11 missing events: actual=%0d left expected=0", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule